// File: doc/BRIEF.md
# Cascadable Addressed Serial Configuration Port

This block receives a serial control word, one bit per rising clock edge, most significant bit first. It is meant for a two-dimensional array of identical devices that all share one serial input line. Each device scans the incoming stream for a start pattern that opens a word. It then checks whether the word's row and column address fields are both zero. A write that matches stores the four 3-bit output codes in a holding (load) register. A separate load pulse copies the holding register into the active configuration register. A read that matches puts the active configuration into the code fields of the word as it passes through.

Every word is also retransmitted on two chain outputs, a row-chain output and a column-chain output, after a fixed pipeline delay. The column-chain copy has its row address reduced by one. The row-chain copy has its column address reduced by one. A word is therefore addressed relative to the position of each device. A device that answers a read turns its own zero address into all ones. Each device further down the chain reduces that value again, so the host can count how many devices the reply crossed.

Top module: `scfg_serial_port`

## Requirements
- R1: A 30-bit word begins when the six most recently sampled bits equal 011111 (write) or 011110 (read). The next bits are the row address (6 bits), then the column address (6 bits), then four 3-bit codes for outputs 1 to 4, each field sent most significant bit first.
- R2: Every bit sampled on `ser_i` at rising edge n appears on `row_so` and `col_so` right after rising edge n+6, which is seven register stages. Bits outside a recognised word pass through unchanged.
- R3: In the word copy on `col_so`, the row address field is reduced by one modulo 64 (0 becomes 111111). All other bits are copied unchanged, except as stated in R8.
- R4: In the word copy on `row_so`, the column address field is reduced by one modulo 64. All other bits are copied unchanged, except as stated in R8.
- R5: A write word with row and column both zero stores its four codes in the holding register. In `cfg_o`, output 1 sits at bits [11:9], output 2 at [8:6], output 3 at [5:3] and output 4 at [2:0].
- R6: A word addressed to any non-zero row or column stores nothing. A bit pattern that starts with an unrecognised start value is not treated as a word: it is forwarded unchanged and stores nothing.
- R7: `cfg_o` changes only at a rising edge where `load_i` is high, and it then takes the holding register's value. A load sampled at the second edge after the final bit of a matching write applies that write's codes.
- R8: A read word with row and column both zero leaves `cfg_o` unchanged. In both forwarded copies, it replaces the four code fields with the current `cfg_o` contents.
- R9: Once a start pattern is recognised, no new start is detected until all 30 bits of that word have been received, even if the word's body contains a start pattern.
- R10: After reset, `cfg_o` is all zeros, both chain outputs are low, and the port waits for a start pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; all sampling is on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_i | input | 1 | Serial control data in |
| load_i | input | 1 | Copies the holding register into the active configuration |
| row_so | output | 1 | Row-chain copy of the stream, column field reduced by one |
| col_so | output | 1 | Column-chain copy of the stream, row field reduced by one |
| cfg_o | output | 12 | Active configuration, four 3-bit output codes |

## Verification
The bench uses the default parameters: 6-bit start and address fields, four 3-bit codes, and a seven-stage forwarding pipe. With these values, a single 30-bit word reaches every case: the address wrapping from zero to all ones, a non-zero address being reduced, a read reply substituted into the code fields, and a word body that itself contains the write start pattern. Each word's two forwarded copies are collected bit by bit at fixed offsets from the input. They are compared with copies the bench builds from the field rules, so a single missing or extra pipeline stage changes the result.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
    // Field widths of the serial control word
    localparam int FRAME_W = 6;
    localparam int ADDR_W  = 6;
    localparam int CODE_W  = 3;
    localparam int NUM_OUT = 4;
    // Forwarding pipe depth (must be at least ADDR_W)
    localparam int FWD_LAT = 7;

    localparam logic [FRAME_W-1:0] WR_FRAME = 6'b011111;
    localparam logic [FRAME_W-1:0] RD_FRAME = 6'b011110;

    localparam int CODE_BITS = NUM_OUT * CODE_W;
    localparam int HDR_W     = FRAME_W + 2 * ADDR_W;
    localparam int WORD_W    = HDR_W + CODE_BITS;
    localparam int CNT_W     = $clog2(WORD_W + 1);
endpackage

// File: rtl/scfg_tracker.sv
// Watches the serial stream, tracks position inside a word and raises
// per-edge strobes for address rewriting, read insertion and capture.
module scfg_tracker
    import scfg_pkg::*;
#(
    parameter int               FRM_W  = FRAME_W,
    parameter int               ADR_W  = ADDR_W,
    parameter int               CBITS  = CODE_BITS,
    parameter logic [FRM_W-1:0] WR_PAT = WR_FRAME,
    parameter logic [FRM_W-1:0] RD_PAT = RD_FRAME
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             si_i,
    output logic                             row_done_o,
    output logic                             col_done_o,
    output logic                             ins_en_o,
    output logic [$clog2(CBITS)-1:0]         ins_idx_o,
    output logic                             cap_o,
    output logic [CBITS-1:0]                 codes_o,
    output logic                             busy_o,
    output logic [$clog2(FRM_W+2*ADR_W+CBITS+1)-1:0] cnt_o
);
    localparam int HDR    = FRM_W + 2 * ADR_W;
    localparam int WORD   = HDR + CBITS;
    localparam int CW     = $clog2(WORD + 1);
    localparam int IDX_W  = $clog2(CBITS);
    localparam int WIN_A  = (2 * ADR_W > CBITS) ? 2 * ADR_W : CBITS;
    localparam int WIN_W  = (WIN_A > FRM_W) ? WIN_A : FRM_W;

    typedef struct packed {
        logic [WIN_W-1:0] win;
        logic             busy;
        logic             rd;
        logic             hit;
        logic [CW-1:0]    cnt;
    } trk_t;

    trk_t st_q, st_d;
    logic [WIN_W-1:0] win_n;

    always_comb begin
        st_d       = st_q;
        win_n      = {st_q.win[WIN_W-2:0], si_i};
        st_d.win   = win_n;
        row_done_o = 1'b0;
        col_done_o = 1'b0;
        ins_en_o   = 1'b0;
        ins_idx_o  = '0;
        cap_o      = 1'b0;
        if (st_q.busy) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_d.cnt == CW'(FRM_W + ADR_W))
                row_done_o = 1'b1;
            if (st_d.cnt == CW'(HDR)) begin
                col_done_o = 1'b1;
                st_d.hit   = (win_n[2*ADR_W-1:0] == '0);
            end
            if (st_d.cnt > CW'(HDR)) begin
                ins_en_o  = st_q.rd && st_q.hit;
                ins_idx_o = IDX_W'(WORD - int'(st_d.cnt));
            end
            if (st_d.cnt == CW'(WORD)) begin
                st_d.busy = 1'b0;
                cap_o     = !st_q.rd && st_q.hit;
            end
        end else begin
            st_d.cnt = '0;
            st_d.hit = 1'b0;
            if (win_n[FRM_W-1:0] == WR_PAT || win_n[FRM_W-1:0] == RD_PAT) begin
                st_d.busy = 1'b1;
                st_d.rd   = (win_n[FRM_W-1:0] == RD_PAT);
                st_d.cnt  = CW'(FRM_W);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign codes_o = win_n[CBITS-1:0];
    assign busy_o  = st_q.busy;
    assign cnt_o   = st_q.cnt;
endmodule

// File: rtl/scfg_fwd_line.sv
// Fixed-depth forwarding pipe; an address field is decremented in place
// on the edge at which its last bit enters.
module scfg_fwd_line #(
    parameter int LAT   = scfg_pkg::FWD_LAT,
    parameter int ADR_W = scfg_pkg::ADDR_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_i,
    input  logic dec_i,
    output logic so_o
);
    logic [LAT-1:0] line_q, line_d;

    always_comb begin
        line_d = {line_q[LAT-2:0], bit_i};
        if (dec_i)
            line_d[ADR_W-1:0] = line_d[ADR_W-1:0] - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

    assign so_o = line_q[LAT-1];
endmodule

// File: rtl/scfg_cfg_regs.sv
// Holding register filled by matching writes, active register filled by load.
module scfg_cfg_regs #(
    parameter int CBITS = scfg_pkg::CODE_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_i,
    input  logic [CBITS-1:0] codes_i,
    input  logic             load_i,
    output logic [CBITS-1:0] cfg_o
);
    typedef struct packed {
        logic [CBITS-1:0] hold;
        logic [CBITS-1:0] act;
    } regs_t;

    regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (cap_i)  r_d.hold = codes_i;
        if (load_i) r_d.act  = r_q.hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cfg_o = r_q.act;
endmodule

// File: rtl/scfg_serial_port.sv
module scfg_serial_port
    import scfg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_i,
    input  logic                 load_i,
    output logic                 row_so,
    output logic                 col_so,
    output logic [CODE_BITS-1:0] cfg_o
);
    localparam int IDX_W  = $clog2(CODE_BITS);
    localparam int N_PATH = 2;   // path 0: row chain, path 1: column chain

    logic             row_done, col_done, ins_en, cap;
    logic [IDX_W-1:0] ins_idx;
    logic [CODE_BITS-1:0] codes;
    logic             trk_busy;
    logic [CNT_W-1:0] trk_cnt;
    logic             fwd_bit;
    logic [N_PATH-1:0] so_vec;

    scfg_tracker u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .si_i       (ser_i),
        .row_done_o (row_done),
        .col_done_o (col_done),
        .ins_en_o   (ins_en),
        .ins_idx_o  (ins_idx),
        .cap_o      (cap),
        .codes_o    (codes),
        .busy_o     (trk_busy),
        .cnt_o      (trk_cnt)
    );

    // Read reply: substitute the active configuration bit as it enters
    assign fwd_bit = ins_en ? cfg_o[ins_idx] : ser_i;

    for (genvar gp = 0; gp < N_PATH; gp++) begin : g_path
        // Row chain rewrites the column field, column chain the row field
        logic dec_sel;
        assign dec_sel = (gp == 0) ? col_done : row_done;
        scfg_fwd_line u_line (
            .clk   (clk),
            .rst_n (rst_n),
            .bit_i (fwd_bit),
            .dec_i (dec_sel),
            .so_o  (so_vec[gp])
        );
    end

    assign row_so = so_vec[0];
    assign col_so = so_vec[1];

    scfg_cfg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_i   (cap),
        .codes_i (codes),
        .load_i  (load_i),
        .cfg_o   (cfg_o)
    );
endmodule

// File: rtl/scfg_serial_port_chk.sv
module scfg_serial_port_chk
    import scfg_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ser_i,
    input logic                 load_i,
    input logic                 row_so,
    input logic                 col_so,
    input logic [CODE_BITS-1:0] cfg_o,
    input logic                 busy,
    input logic [CNT_W-1:0]     cnt
);
    localparam int QW = $clog2(FWD_LAT + 1);

    logic [FWD_LAT-1:0] hist_q;
    logic [QW-1:0]      quiet_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q  <= '0;
            quiet_q <= '0;
        end else begin
            hist_q <= {hist_q[FWD_LAT-2:0], ser_i};
            if (busy)                      quiet_q <= '0;
            else if (quiet_q < QW'(FWD_LAT)) quiet_q <= quiet_q + 1'b1;
        end
    end

    // R2
    row_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_q >= QW'(FWD_LAT)) |-> (row_so == hist_q[FWD_LAT-1]));

    // R2
    col_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_q >= QW'(FWD_LAT)) |-> (col_so == hist_q[FWD_LAT-1]));

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(cfg_o));

    // R1
    word_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (cnt == CNT_W'(FRAME_W)));

    // R9
    word_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (cnt == CNT_W'(WORD_W)));
endmodule

bind scfg_serial_port scfg_serial_port_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ser_i  (ser_i),
    .load_i (load_i),
    .row_so (row_so),
    .col_so (col_so),
    .cfg_o  (cfg_o),
    .busy   (trk_busy),
    .cnt    (trk_cnt)
);

// File: tb/scfg_serial_port_tb.sv
module scfg_serial_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [5:0] WRF = 6'b011111;
    localparam logic [5:0] RDF = 6'b011110;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_i = 1'b0;
    logic        load_i = 1'b0;
    logic        row_so, col_so;
    logic [11:0] cfg_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [11:0] cfg_m = 12'h000;   // bench model of the active configuration

    always #(CLK_PERIOD/2) clk = ~clk;

    scfg_serial_port u_dut (
        .clk(clk), .rst_n(rst_n), .ser_i(ser_i), .load_i(load_i),
        .row_so(row_so), .col_so(col_so), .cfg_o(cfg_o)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic [29:0] mk(input logic [5:0] fr, input logic [5:0] r,
                                       input logic [5:0] c, input logic [11:0] cd);
        return {fr, r, c, cd};
    endfunction

    // Expected forwarded copy from the field rules
    function automatic logic [29:0] exp_fwd(input logic [29:0] w, input bit rowpath,
                                            input logic [11:0] cfgv);
        logic [5:0] fr, r, c;
        logic [11:0] cd;
        fr = w[29:24]; r = w[23:18]; c = w[17:12]; cd = w[11:0];
        if (fr == WRF || fr == RDF) begin
            if (fr == RDF && r == 6'd0 && c == 6'd0) cd = cfgv;
            if (rowpath) c = c - 6'd1;
            else         r = r - 6'd1;
        end
        return {fr, r, c, cd};
    endfunction

    // Shift a word in, then zeros; collect both outputs 7 edges delayed
    task automatic send(input logic [29:0] w, output logic [29:0] rg, output logic [29:0] cg);
        rg = '0; cg = '0;
        for (int k = 0; k <= 36; k++) begin
            @(negedge clk);
            if (k >= 7) begin
                rg[29-(k-7)] = row_so;
                cg[29-(k-7)] = col_so;
            end
            ser_i = (k < 30) ? w[29-k] : 1'b0;
        end
    endtask

    task automatic pulse_load();
        @(negedge clk); load_i = 1'b1;
        @(negedge clk); load_i = 1'b0;
    endtask

    task automatic word_check(input string req, input logic [29:0] w);
        logic [29:0] rg, cg;
        send(w, rg, cg);
        chk({req, " row chain"}, 32'(rg), 32'(exp_fwd(w, 1'b1, cfg_m)));
        chk({req, " column chain"}, 32'(cg), 32'(exp_fwd(w, 1'b0, cfg_m)));
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R10 cfg after reset", 32'(cfg_o), 32'h0);
        chk("R10 row_so after reset", 32'(row_so), 32'h0);
        chk("R10 col_so after reset", 32'(col_so), 32'h0);
    endtask

    task automatic t_write_hit();
        logic [11:0] a = {3'd1, 3'd2, 3'd3, 3'd4};
        word_check("R1 R3 R4 write hit", mk(WRF, 6'd0, 6'd0, a));
        chk("R7 cfg before load", 32'(cfg_o), 32'(cfg_m));
        pulse_load();
        cfg_m = a;
        chk("R5 cfg after load", 32'(cfg_o), 32'(a));
        chk("R5 output1 field at [11:9]", 32'(cfg_o[11:9]), 32'd1);
        chk("R5 output4 field at [2:0]", 32'(cfg_o[2:0]), 32'd4);
    endtask

    task automatic t_load_timing();
        logic [11:0] b = {3'd4, 3'd3, 3'd2, 3'd1};
        logic [29:0] w = mk(WRF, 6'd0, 6'd0, b);
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            ser_i = w[29-k];
        end
        @(negedge clk); ser_i = 1'b0;          // edge 30 samples final bit
        @(negedge clk);                        // after edge 31
        chk("R7 cfg not applied before load", 32'(cfg_o), 32'(cfg_m));
        load_i = 1'b1;                         // sampled at edge 32
        @(negedge clk); load_i = 1'b0;
        cfg_m = b;
        chk("R7 load at second edge after last bit", 32'(cfg_o), 32'(b));
        repeat (8) @(negedge clk);
    endtask

    task automatic t_write_miss();
        word_check("R4 R6 write to row 1", mk(WRF, 6'd1, 6'd0, {3'd5, 3'd5, 3'd5, 3'd5}));
        pulse_load();
        chk("R6 miss stores nothing", 32'(cfg_o), 32'(cfg_m));
    endtask

    task automatic t_read_hit();
        word_check("R8 read hit", mk(RDF, 6'd0, 6'd0, 12'h000));
        chk("R8 cfg unchanged by read", 32'(cfg_o), 32'(cfg_m));
    endtask

    task automatic t_read_miss();
        word_check("R3 R4 read miss nonzero address", mk(RDF, 6'd2, 6'd5, 12'h000));
    endtask

    task automatic t_bad_frame();
        word_check("R6 unrecognised start", mk(6'b011101, 6'd0, 6'd0, {3'd1, 3'd2, 3'd3, 3'd4}));
        pulse_load();
        chk("R6 unrecognised start stores nothing", 32'(cfg_o), 32'(cfg_m));
    endtask

    task automatic t_suppress();
        logic [11:0] d = {3'b011, 3'b111, 3'b100, 3'b000};
        word_check("R9 start pattern inside body", mk(WRF, 6'd0, 6'd0, d));
        pulse_load();
        cfg_m = d;
        chk("R9 body pattern still captured", 32'(cfg_o), 32'(d));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_hit();
        t_load_timing();
        t_write_miss();
        t_read_hit();
        t_read_miss();
        t_bad_frame();
        t_suppress();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule